// File: doc/BRIEF.md
# Indirect Branch Target Cache

This block predicts where an indirect branch will go. It is a set-associative table of branch targets. Each entry is identified by a tag cut from the word-aligned branch address. The row, or set, is picked by folding three values together with XOR: the word-aligned branch address, the global direction history, and a few of the most recent indirect targets on the current path. Each of those path targets is shifted right by a larger amount before it is folded in. A fetch stage presents the branch address, the history and the path targets on the lookup port. In the same cycle it gets back a hit flag and, on a hit, the stored target.

When a branch resolves to a target the table did not give, the back end drives the update port. It supplies the branch address, the corrected target, and the history and path snapshot recorded when that branch was predicted. That path snapshot leaves out the branch's own entry. The update port computes its own set index from this snapshot, so it does not depend on what the lookup port sees at that moment. If a way in the indexed set already holds the tag, only that way's target is rewritten. Otherwise a way chosen by a free-running LFSR receives the new tag and target. A write lands at the next clock edge. A lookup made in the same cycle still sees the old contents.

Top module: `ind_tgt_cache`

## Requirements
- R1: After reset every way is invalid. Until something is written, every lookup misses. While `lk_hit` is 0, `lk_target` reads 0.
- R2: The tag is bits [SHIFT+TAG_W-1:SHIFT] of the branch address (bits 17:2 by default). The address bits below SHIFT never affect a lookup, and neither do the bits above the tag and above the index field.
- R3: With history hashing on, the global history is XORed into the word-aligned address before the index is cut. History bits at positions IDX_W and above (bit 8 and up by default) do not change the set.
- R4: With path hashing on, path slot p (slot 0 is the most recent, at bits [p*ADDR_W +: ADDR_W]) is shifted right by SHIFT + p*floor(IDX_W/PATH_LEN) and XORed in. Only slots below the slot count take part. The set index is the low IDX_W bits of the combined hash.
- R5: A lookup hits when a valid way in the selected set holds the tag. It then returns that way's target, and the result is available combinationally in the same cycle.
- R6: An update whose tag is already present in its set rewrites only that way's target. Repeated updates of one branch leave exactly one live copy, which holds the latest target.
- R7: An update whose tag is absent writes the tag and target into the way picked by the LFSR. The new entry always hits afterwards, and a set never holds more than WAYS distinct tags.
- R8: An update takes effect at the next rising edge. A lookup in the same cycle as the update returns the previous contents.
- R9: The update port's set index comes only from its own address, history, path and slot-count inputs, not from the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_pc | input | ADDR_W | Address of the branch being predicted |
| lk_hist | input | HIST_W | Global direction history for the lookup |
| lk_path | input | PATH_LEN*ADDR_W | Recent indirect targets, slot 0 most recent in the low bits |
| lk_pcnt | input | CNT_W | Number of valid path slots for the lookup |
| lk_hit | output | 1 | A valid way matched the tag |
| lk_target | output | ADDR_W | Predicted target, zero on a miss |
| up_en | input | 1 | Write a corrected target this cycle |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_hist | input | HIST_W | History snapshot taken when the branch was predicted |
| up_path | input | PATH_LEN*ADDR_W | Path snapshot that excludes the branch's own entry |
| up_pcnt | input | CNT_W | Number of valid path slots in the snapshot |
| up_target | input | ADDR_W | Corrected target |

## Verification
The hash is probed with pairs of inputs that differ in a single bit. The bench checks that a flip which lands inside the index field turns a hit into a miss, and that one which falls off the top after its shift leaves the hit intact. This separates the shift amount used for each path slot and the width of the index mask. A combined flip of a history bit and a path-slot bit that land on the same index bit must cancel, which confirms that the terms are XORed rather than ORed or added. Further cases check address aliasing below the shift and above the tag, rewrites of one branch against fresh allocations in a crowded set, and a lookup made in the same cycle as a write.

// File: rtl/itc_pkg.sv
package itc_pkg;
  // Victim-selection LFSR width and Galois feedback taps (maximal length).
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'h0001;
endpackage

// File: rtl/itc_hash.sv
// Set index and tag generation from address, history and path targets.
module itc_hash #(
  parameter int ADDR_W    = 32,
  parameter int HIST_W    = 13,
  parameter int PATH_LEN  = 3,
  parameter int CNT_W     = 2,
  parameter int SHIFT     = 2,
  parameter int IDX_W     = 8,
  parameter int TAG_W     = 16,
  parameter bit HASH_HIST = 1'b1,
  parameter bit HASH_PATH = 1'b1
) (
  input  logic [ADDR_W-1:0]          pc,
  input  logic [HIST_W-1:0]          hist,
  input  logic [PATH_LEN*ADDR_W-1:0] path,
  input  logic [CNT_W-1:0]           pcnt,
  output logic [IDX_W-1:0]           idx,
  output logic [TAG_W-1:0]           tag
);
  localparam int STEP = IDX_W / PATH_LEN;

  logic [ADDR_W-1:0] pc_sh;
  logic [ADDR_W-1:0] acc;

  assign pc_sh = pc >> SHIFT;

  always_comb begin
    acc = pc_sh;
    if (HASH_HIST) begin
      acc = acc ^ ADDR_W'(hist);
    end
    if (HASH_PATH) begin
      for (int p = 0; p < PATH_LEN; p++) begin
        if (p < int'(pcnt)) begin
          acc = acc ^ (path[p*ADDR_W +: ADDR_W] >> (SHIFT + p*STEP));
        end
      end
    end
  end

  assign idx = acc[IDX_W-1:0];
  assign tag = pc_sh[TAG_W-1:0];
endmodule

// File: rtl/itc_lfsr.sv
// Free-running Galois LFSR used to pick allocation victims.
module itc_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] state_d;
  logic [W-1:0] state_q;

  always_comb begin
    state_d = {1'b0, state_q[W-1:1]};
    if (state_q[0]) begin
      state_d = state_d ^ TAPS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/itc_store.sv
// Tag/target arrays with lookup compare and update-or-allocate.
module itc_store #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256,
  parameter int WAYS   = 2,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 16,
  parameter int WAY_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [WAY_W-1:0]  victim
);
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [SETS-1:0][WAYS-1:0] vld_d;
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [ADDR_W-1:0] tgt_q [SETS][WAYS];

  logic [WAYS-1:0]   rd_match;
  logic [WAYS-1:0]   wr_match;
  logic              wr_hit;
  logic [WAY_W-1:0]  wr_way;

  // Per-way compare for both ports.
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign rd_match[w] = vld_q[rd_idx][w] && (tag_q[rd_idx][w] == rd_tag);
    assign wr_match[w] = vld_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
  end

  // Lookup: lowest matching way wins, zero target on a miss.
  always_comb begin
    rd_hit    = 1'b0;
    rd_target = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (rd_match[w]) begin
        rd_hit    = 1'b1;
        rd_target = tgt_q[rd_idx][w];
      end
    end
  end

  // Update: reuse a matching way, else take the victim.
  always_comb begin
    wr_hit = 1'b0;
    wr_way = victim;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (wr_match[w]) begin
        wr_hit = 1'b1;
        wr_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[wr_idx][wr_way] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Payload arrays carry no reset; valid bits qualify them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (!wr_hit) begin
        tag_q[wr_idx][wr_way] <= wr_tag;
      end
      tgt_q[wr_idx][wr_way] <= wr_target;
    end
  end
endmodule

// File: rtl/ind_tgt_cache.sv
module ind_tgt_cache #(
  parameter int ADDR_W    = 32,
  parameter int SETS      = 256,
  parameter int WAYS      = 2,
  parameter int TAG_W     = 16,
  parameter int SHIFT     = 2,
  parameter int HIST_W    = 13,
  parameter int PATH_LEN  = 3,
  parameter bit HASH_HIST = 1'b1,
  parameter bit HASH_PATH = 1'b1,
  localparam int CNT_W    = $clog2(PATH_LEN + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          lk_pc,
  input  logic [HIST_W-1:0]          lk_hist,
  input  logic [PATH_LEN*ADDR_W-1:0] lk_path,
  input  logic [CNT_W-1:0]           lk_pcnt,
  output logic                       lk_hit,
  output logic [ADDR_W-1:0]          lk_target,
  input  logic                       up_en,
  input  logic [ADDR_W-1:0]          up_pc,
  input  logic [HIST_W-1:0]          up_hist,
  input  logic [PATH_LEN*ADDR_W-1:0] up_path,
  input  logic [CNT_W-1:0]           up_pcnt,
  input  logic [ADDR_W-1:0]          up_target
);
  import itc_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [IDX_W-1:0]  up_idx;
  logic [TAG_W-1:0]  up_tag;
  logic [LFSR_W-1:0] lfsr_q;
  logic [WAY_W-1:0]  victim;

  itc_hash #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PATH_LEN(PATH_LEN), .CNT_W(CNT_W),
    .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .HASH_HIST(HASH_HIST), .HASH_PATH(HASH_PATH)
  ) u_hash_lk (
    .pc(lk_pc), .hist(lk_hist), .path(lk_path), .pcnt(lk_pcnt),
    .idx(lk_idx), .tag(lk_tag)
  );

  itc_hash #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PATH_LEN(PATH_LEN), .CNT_W(CNT_W),
    .SHIFT(SHIFT), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .HASH_HIST(HASH_HIST), .HASH_PATH(HASH_PATH)
  ) u_hash_up (
    .pc(up_pc), .hist(up_hist), .path(up_path), .pcnt(up_pcnt),
    .idx(up_idx), .tag(up_tag)
  );

  itc_lfsr #(
    .W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_int_n), .state(lfsr_q)
  );

  assign victim = WAY_W'(lfsr_q % LFSR_W'(WAYS));

  itc_store #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(lk_idx), .rd_tag(lk_tag),
    .rd_hit(lk_hit), .rd_target(lk_target),
    .wr_en(up_en), .wr_idx(up_idx), .wr_tag(up_tag),
    .wr_target(up_target), .victim(victim)
  );
endmodule

// File: rtl/itc_chk.sv
module itc_chk #(
  parameter int ADDR_W   = 32,
  parameter int HIST_W   = 13,
  parameter int PATH_LEN = 3,
  parameter int CNT_W    = 2,
  parameter int LFSR_W   = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          lk_pc,
  input logic [HIST_W-1:0]          lk_hist,
  input logic [PATH_LEN*ADDR_W-1:0] lk_path,
  input logic [CNT_W-1:0]           lk_pcnt,
  input logic                       lk_hit,
  input logic [ADDR_W-1:0]          lk_target,
  input logic                       up_en,
  input logic [ADDR_W-1:0]          up_pc,
  input logic [HIST_W-1:0]          up_hist,
  input logic [PATH_LEN*ADDR_W-1:0] up_path,
  input logic [CNT_W-1:0]           up_pcnt,
  input logic [ADDR_W-1:0]          up_target,
  input logic [LFSR_W-1:0]          lfsr
);
  logic seen_up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_up_q <= 1'b0;
    end else if (up_en) begin
      seen_up_q <= 1'b1;
    end
  end

  // R1: nothing written since reset means every lookup misses.
  assert_empty_miss_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_up_q |-> !lk_hit);

  // R5: the hit flag is always a known value.
  assert_hit_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(lk_hit));

  // R7: an update is visible to an identical lookup on the following cycle.
  assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    up_en |=> ((lk_pc == $past(up_pc) && lk_hist == $past(up_hist) &&
                lk_path == $past(up_path) && lk_pcnt == $past(up_pcnt))
               -> (lk_hit && lk_target == $past(up_target))));

  // R7: victim source never locks up at zero.
  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R8: with no write on the previous edge and steady inputs, the answer holds.
  assert_no_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(up_en) && $stable(lk_pc) && $stable(lk_hist) &&
     $stable(lk_path) && $stable(lk_pcnt))
    |-> ($stable(lk_hit) && $stable(lk_target)));
endmodule

bind ind_tgt_cache itc_chk #(
  .ADDR_W(ADDR_W), .HIST_W(HIST_W), .PATH_LEN(PATH_LEN),
  .CNT_W(CNT_W), .LFSR_W(itc_pkg::LFSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_path(lk_path), .lk_pcnt(lk_pcnt),
  .lk_hit(lk_hit), .lk_target(lk_target),
  .up_en(up_en), .up_pc(up_pc), .up_hist(up_hist), .up_path(up_path),
  .up_pcnt(up_pcnt), .up_target(up_target), .lfsr(lfsr_q)
);

// File: tb/ind_tgt_cache_tb.sv
module ind_tgt_cache_tb;
  localparam int AW = 32;
  localparam int HW = 13;
  localparam int PL = 3;
  localparam int CW = 2;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] lk_pc;
  logic [HW-1:0] lk_hist;
  logic [PL*AW-1:0] lk_path;
  logic [CW-1:0] lk_pcnt;
  logic          lk_hit;
  logic [AW-1:0] lk_target;
  logic          up_en;
  logic [AW-1:0] up_pc;
  logic [HW-1:0] up_hist;
  logic [PL*AW-1:0] up_path;
  logic [CW-1:0] up_pcnt;
  logic [AW-1:0] up_target;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  ind_tgt_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_path(lk_path), .lk_pcnt(lk_pcnt),
    .lk_hit(lk_hit), .lk_target(lk_target),
    .up_en(up_en), .up_pc(up_pc), .up_hist(up_hist), .up_path(up_path),
    .up_pcnt(up_pcnt), .up_target(up_target)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [PL*AW-1:0] mkp(input logic [AW-1:0] s0, s1, s2);
    return {s2, s1, s0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] pc, input logic [HW-1:0] h,
                    input logic [PL*AW-1:0] p, input logic [CW-1:0] c,
                    input logic [AW-1:0] t);
    @(negedge clk);
    up_en = 1'b1; up_pc = pc; up_hist = h; up_path = p; up_pcnt = c; up_target = t;
    @(negedge clk);
    up_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] pc, input logic [HW-1:0] h,
                    input logic [PL*AW-1:0] p, input logic [CW-1:0] c,
                    output logic hit, output logic [AW-1:0] t);
    @(negedge clk);
    lk_pc = pc; lk_hist = h; lk_path = p; lk_pcnt = c;
    #1;
    hit = lk_hit; t = lk_target;
  endtask

  // Expect a hit with a given target.
  task automatic exp_hit(input string req, input logic [AW-1:0] pc, input logic [HW-1:0] h,
                         input logic [PL*AW-1:0] p, input logic [CW-1:0] c,
                         input logic [AW-1:0] t);
    logic hh; logic [AW-1:0] tt;
    rd(pc, h, p, c, hh, tt);
    chk(hh === 1'b1, {req, " hit"}, AW'(hh), 1);
    chk(tt === t, {req, " target"}, tt, t);
  endtask

  task automatic exp_miss(input string req, input logic [AW-1:0] pc, input logic [HW-1:0] h,
                          input logic [PL*AW-1:0] p, input logic [CW-1:0] c);
    logic hh; logic [AW-1:0] tt;
    rd(pc, h, p, c, hh, tt);
    chk(hh === 1'b0, {req, " miss"}, AW'(hh), 0);
    chk(tt === '0, {req, " zero target"}, tt, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    exp_miss("R1 empty a", 32'h0000_1040, '0, '0, '0);
    exp_miss("R1 empty b", 32'h0000_2080, 13'h1F, mkp(32'h10, 0, 0), 2'd1);
  endtask

  task automatic t_basic();
    wr(32'h0000_1040, '0, '0, '0, 32'hA000_0040);
    wr(32'h0000_2080, '0, '0, '0, 32'hB000_0080);
    exp_hit("R5 entry a", 32'h0000_1040, '0, '0, '0, 32'hA000_0040);
    exp_hit("R5 entry b", 32'h0000_2080, '0, '0, '0, 32'hB000_0080);
  endtask

  task automatic t_tag();
    exp_hit("R2 low bits ignored", 32'h0000_1043, '0, '0, '0, 32'hA000_0040);
    exp_hit("R2 high bits ignored", 32'h0010_1040, '0, '0, '0, 32'hA000_0040);
    exp_miss("R2 tag bit differs", 32'h0000_1040 ^ 32'h1000, '0, '0, '0);
  endtask

  task automatic t_same_cycle();
    logic hh;
    @(negedge clk);
    up_en = 1'b1; up_pc = 32'h0000_30C0; up_hist = '0; up_path = '0; up_pcnt = '0;
    up_target = 32'hC000_00C0;
    lk_pc = 32'h0000_30C0; lk_hist = '0; lk_path = '0; lk_pcnt = '0;
    #1;
    hh = lk_hit;
    chk(hh === 1'b0, "R8 same-cycle sees old", AW'(hh), 0);
    @(negedge clk);
    up_en = 1'b0;
    #1;
    chk(lk_hit === 1'b1, "R8 visible after edge", AW'(lk_hit), 1);
    chk(lk_target === 32'hC000_00C0, "R8 target after edge", lk_target, 32'hC000_00C0);
  endtask

  task automatic t_hist();
    wr(32'h0000_4100, 13'h005, '0, '0, 32'hD000_0100);
    exp_hit("R3 same history", 32'h0000_4100, 13'h005, '0, '0, 32'hD000_0100);
    exp_miss("R3 history bit0 moves set", 32'h0000_4100, 13'h004, '0, '0);
    exp_hit("R3 history above index masked", 32'h0000_4100, 13'h405, '0, '0, 32'hD000_0100);
  endtask

  task automatic t_path();
    logic [PL*AW-1:0] p;
    p = mkp(32'h20, 32'h40, 32'h80);
    wr(32'h0000_5140, '0, p, 2'd3, 32'hE000_0140);
    exp_hit("R4 same path", 32'h0000_5140, '0, p, 2'd3, 32'hE000_0140);
    exp_miss("R4 slot1 shift 4", 32'h0000_5140, '0, mkp(32'h20, 32'h50, 32'h80), 2'd3);
    exp_hit("R4 slot1 bit falls off index", 32'h0000_5140, '0,
            mkp(32'h20, 32'h1040, 32'h80), 2'd3, 32'hE000_0140);
    exp_miss("R4 slot2 shift 6", 32'h0000_5140, '0, mkp(32'h20, 32'h40, 32'hC0), 2'd3);
    exp_hit("R4 history and slot0 cancel", 32'h0000_5140, 13'h001,
            mkp(32'h24, 32'h40, 32'h80), 2'd3, 32'hE000_0140);
    wr(32'h0000_6180, '0, mkp(0, 32'h30, 0), 2'd1, 32'hF000_0180);
    exp_hit("R4 slot beyond count ignored", 32'h0000_6180, '0,
            mkp(0, 32'h70, 0), 2'd1, 32'hF000_0180);
    exp_miss("R4 slot within count used", 32'h0000_6180, '0, mkp(0, 32'h30, 0), 2'd2);
  endtask

  task automatic t_split();
    @(negedge clk);
    lk_pc = 32'h0000_71C0; lk_hist = 13'h005; lk_path = '0; lk_pcnt = '0;
    wr(32'h0000_71C0, 13'h00A, '0, '0, 32'h1200_01C0);
    exp_hit("R9 update used own history", 32'h0000_71C0, 13'h00A, '0, '0, 32'h1200_01C0);
    exp_miss("R9 lookup-port history not used", 32'h0000_71C0, 13'h005, '0, '0);
  endtask

  task automatic t_overwrite();
    wr(32'h0000_8200, '0, '0, '0, 32'h3300_0001);
    for (int i = 0; i < 5; i++) begin
      wr(32'h0000_8200, '0, '0, '0, 32'h3300_0010 + i);
    end
    exp_hit("R6 latest target kept", 32'h0000_8200, '0, '0, '0, 32'h3300_0014);
    wr(32'h0000_8200, '0, '0, '0, 32'h3300_0099);
    exp_hit("R6 rewrite again", 32'h0000_8200, '0, '0, '0, 32'h3300_0099);
  endtask

  task automatic t_alloc();
    int nhit;
    logic hh; logic [AW-1:0] tt;
    nhit = 0;
    wr(32'h0000_0640, '0, '0, '0, 32'h4400_0001);
    wr(32'h0000_0A40, '0, '0, '0, 32'h4400_0002);
    wr(32'h0000_0E40, '0, '0, '0, 32'h4400_0003);
    exp_hit("R7 newest allocation hits", 32'h0000_0E40, '0, '0, '0, 32'h4400_0003);
    rd(32'h0000_0640, '0, '0, '0, hh, tt);
    if (hh) begin
      nhit++;
      chk(tt === 32'h4400_0001, "R7 survivor a target", tt, 32'h4400_0001);
    end
    rd(32'h0000_0A40, '0, '0, '0, hh, tt);
    if (hh) begin
      nhit++;
      chk(tt === 32'h4400_0002, "R7 survivor b target", tt, 32'h4400_0002);
    end
    chk(nhit <= 1, "R7 set holds at most WAYS tags", AW'(nhit + 1), 2);
  endtask

  task automatic t_reset_again();
    do_reset();
    exp_miss("R1 cleared by reset a", 32'h0000_1040, '0, '0, '0);
    exp_miss("R1 cleared by reset b", 32'h0000_8200, '0, '0, '0);
  endtask

  initial begin
    rst_n = 1'b0;
    up_en = 1'b0; up_pc = '0; up_hist = '0; up_path = '0; up_pcnt = '0; up_target = '0;
    lk_pc = '0; lk_hist = '0; lk_path = '0; lk_pcnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_tag();
    t_same_cycle();
    t_hist();
    t_path();
    t_split();
    t_overwrite();
    t_alloc();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule